// File: doc/BRIEF.md
# Pointer-Decoupled Cache Tag Directory

This block is the tag directory of a cache whose tag entries and data lines are linked by pointers instead of by position. The tag store is indexed by set and has twice as many entries as there are data lines. Every valid tag entry holds a forward pointer to the data line it uses. Every valid data line holds a reverse pointer back to the tag entry that owns it. Because a set can fill any of its tag entries with any data line, a heavily used set can keep more valid ways than an even share of the lines would give it, while a quiet set keeps fewer.

A lookup is combinational. It compares the tags of the indexed set and returns the hit flag together with the data-line index taken from the matching entry's forward pointer. A fill installs an address that has missed. If the indexed set still has an invalid tag entry, the directory asks an external global victim selector for a data line over a request/grant pair. If that line already belongs to a tag entry, the reverse pointer identifies that entry and it is invalidated in the same cycle as the new entry is written. If the set has no invalid entry, the directory evicts the set's least recently used tag entry and reuses its data line, without making a request. The data payload and the next memory level are outside the block.

Top module: `vw_dir`

## Requirements
- R1: An address is split into a line offset (the low OFF_W bits, which are ignored), a set index (the next SET_W bits) and a tag (the remaining upper bits). Two addresses that differ only in the offset map to the same entry, and the same tag in another set is a separate entry.
- R2: After reset every tag entry and every data line is invalid. No lookup hits, and the first fill into any set raises `vic_req`.
- R3: While `lk_valid` is high and the lookup is not stalled, `lk_hit` and `lk_line` reflect the directory in the same cycle. On a hit, `lk_line` equals the data-line index that was reported on `fill_line` when the address was installed.
- R4: A lookup of an address that is not installed gives `lk_hit` = 0. At most one tag entry of a set matches a lookup.
- R5: A single set can hold up to WAYS valid tags at once, which is more than the LINES/SETS lines an even split would give it. All of them hit.
- R6: A fill whose set has an invalid tag entry raises `vic_req` and waits with `fill_done` low until `vic_gnt`. It completes in the grant cycle, with `fill_line` equal to `vic_line`.
- R7: When the granted line already belonged to a tag entry, that entry is invalidated in the fill cycle, so a later lookup of its address misses. Entries in other sets are not affected.
- R8: A fill into a set whose WAYS entries are all valid keeps `vic_req` low and completes in the same cycle. It evicts the least recently used entry of that set and reports that entry's old data line on `fill_line`. The evicted address then misses.
- R9: Both a lookup hit and a fill count as a use for recency. An entry that was hit after later entries were filled is not the one evicted.
- R10: If a lookup comes in the same cycle as an active fill (`fill_valid` high) to the same set, the fill takes priority. `lk_stall` is 1, `lk_hit` is 0 and recency is not updated.
- R11: A lookup to a different set is served normally while a fill waits for its grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_stall | output | 1 | Lookup blocked by a fill to the same set; retry |
| lk_line | output | LINE_W | Data-line index of the hit |
| fill_valid | input | 1 | Fill request, held until `fill_done` |
| fill_addr | input | ADDR_W | Address to install (must currently miss) |
| fill_done | output | 1 | Fill is written at this clock edge |
| fill_line | output | LINE_W | Data line assigned to the filled address |
| vic_req | output | 1 | Request for a globally chosen victim line |
| vic_gnt | input | 1 | Victim line is valid on `vic_line` |
| vic_line | input | LINE_W | Victim data-line index from the global selector |

## Verification
A broken forward pointer shows at the lookup port in the first hit on that address: `lk_line` no longer matches the `fill_line` reported at install. A reverse pointer that is missing or points to the wrong entry leaves a stale tag alive. That stale tag then hits on a line that was handed to another address, and it shows on the first lookup of the old address after the line is reassigned. Wrong recency or wrong valid bits change which line is reported on a fill into a full set, and whether `vic_req` rises, at that very fill. So every internal fault surfaces within one lookup or fill of the corrupted set.

// File: rtl/vw_dir_pkg.sv
package vw_dir_pkg;

  // width of the use stamps kept per tag entry
  parameter int unsigned STAMP_W = 16;

  typedef logic [STAMP_W-1:0] stamp_t;

  // cycles of use since an entry was last touched (modular)
  function automatic stamp_t age_of(input stamp_t now, input stamp_t stamp);
    return now - stamp;
  endfunction

endpackage

// File: rtl/vw_way_pick.sv
module vw_way_pick
  import vw_dir_pkg::*;
#(
  parameter int unsigned WAYS = 16,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  stamp_t                  now,
  input  logic   [WAYS-1:0]       valid,
  input  stamp_t [WAYS-1:0]       stamps,
  output logic                    free_any,
  output logic   [WAY_W-1:0]      free_way,
  output logic   [WAY_W-1:0]      lru_way
);

  stamp_t best_age;

  // lowest-numbered invalid entry
  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  // oldest valid entry; valid stamps are always older than now
  always_comb begin
    best_age = '0;
    lru_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid[w] && (age_of(now, stamps[w]) > best_age)) begin
        best_age = age_of(now, stamps[w]);
        lru_way  = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/vw_tag_store.sv
module vw_tag_store
  import vw_dir_pkg::*;
#(
  parameter int unsigned SET_W  = 2,
  parameter int unsigned WAYS   = 16,
  parameter int unsigned TAG_W  = 10,
  parameter int unsigned LINE_W = 5,
  localparam int unsigned SETS  = 1 << SET_W,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  // lookup read
  input  logic [SET_W-1:0]             lk_set,
  input  logic [TAG_W-1:0]             lk_tag,
  output logic [WAYS-1:0]              lk_match,
  output logic                         lk_any,
  output logic [WAY_W-1:0]             lk_way,
  output logic [LINE_W-1:0]            lk_line,
  // fill-side read of one whole set
  input  logic [SET_W-1:0]             pk_set,
  output logic [WAYS-1:0]              pk_valid,
  output stamp_t [WAYS-1:0]            pk_stamps,
  output logic [WAYS-1:0][LINE_W-1:0]  pk_fptr,
  // owner invalidation
  input  logic                         inv_en,
  input  logic [SET_W-1:0]             inv_set,
  input  logic [WAY_W-1:0]             inv_way,
  // install
  input  logic                         wr_en,
  input  logic [SET_W-1:0]             wr_set,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [LINE_W-1:0]            wr_line,
  // recency update on hit
  input  logic                         touch_en,
  input  logic [SET_W-1:0]             touch_set,
  input  logic [WAY_W-1:0]             touch_way,
  input  stamp_t                       now
);

  logic [WAYS-1:0]   val_q   [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [LINE_W-1:0] fptr_q  [SETS][WAYS];
  stamp_t            stamp_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else begin
      if (inv_en) val_q[inv_set][inv_way] <= 1'b0;
      if (wr_en)  val_q[wr_set][wr_way]   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]   <= wr_tag;
      fptr_q[wr_set][wr_way]  <= wr_line;
      stamp_q[wr_set][wr_way] <= now;
    end
    if (touch_en) stamp_q[touch_set][touch_way] <= now;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lk_match[w]  = val_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign pk_valid[w]  = val_q[pk_set][w];
    assign pk_stamps[w] = stamp_q[pk_set][w];
    assign pk_fptr[w]   = fptr_q[pk_set][w];
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) lk_way = WAY_W'(w);
    end
  end

  assign lk_any  = |lk_match;
  assign lk_line = fptr_q[lk_set][lk_way];

endmodule

// File: rtl/vw_line_store.sv
module vw_line_store #(
  parameter int unsigned LINES = 32,
  parameter int unsigned OWN_W = 6,
  localparam int unsigned LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [OWN_W-1:0]  wr_own,
  input  logic [LINE_W-1:0] rd_line,
  output logic              rd_valid,
  output logic [OWN_W-1:0]  rd_own
);

  logic [LINES-1:0] val_q;
  logic [OWN_W-1:0] rptr_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n)     val_q <= '0;
    else if (wr_en) val_q[wr_line] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) rptr_q[wr_line] <= wr_own;
  end

  assign rd_valid = val_q[rd_line];
  assign rd_own   = rptr_q[rd_line];

endmodule

// File: rtl/vw_dir.sv
module vw_dir
  import vw_dir_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned SET_W  = 2,
  parameter int unsigned WAYS   = 16,
  localparam int unsigned TAG_W  = ADDR_W - SET_W - OFF_W,
  localparam int unsigned SETS   = 1 << SET_W,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned LINES  = (SETS * WAYS) / 2,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned OWN_W  = SET_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_stall,
  output logic [LINE_W-1:0] lk_line,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              fill_done,
  output logic [LINE_W-1:0] fill_line,
  output logic              vic_req,
  input  logic              vic_gnt,
  input  logic [LINE_W-1:0] vic_line
);

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic unused_offset_bits;
  assign unused_offset_bits = ^{lk_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  logic [SET_W-1:0] lk_set, fill_set, inv_set;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  assign lk_set   = set_of(lk_addr);
  assign lk_tag   = tag_of(lk_addr);
  assign fill_set = set_of(fill_addr);
  assign fill_tag = tag_of(fill_addr);

  // named internal events
  logic [WAYS-1:0]             lk_match_vec;
  logic                        lk_any;
  logic [WAY_W-1:0]            lk_way, inv_way, free_way, lru_way, new_way;
  logic [WAYS-1:0]             pk_valid;
  stamp_t [WAYS-1:0]           pk_stamps;
  logic [WAYS-1:0][LINE_W-1:0] pk_fptr;
  logic                        free_any, inv_en, touch_en;
  logic                        vl_valid;
  logic [OWN_W-1:0]            vl_own;
  logic [LINE_W-1:0]           new_line;
  stamp_t                      now_q;

  // fill path
  assign vic_req   = fill_valid && free_any;
  assign fill_done = fill_valid && (!free_any || vic_gnt);
  assign new_way   = free_any ? free_way : lru_way;
  assign new_line  = free_any ? vic_line : pk_fptr[lru_way];
  assign fill_line = new_line;

  // previous owner of a globally chosen line loses it
  assign inv_en  = fill_done && free_any && vl_valid;
  assign inv_set = vl_own[OWN_W-1:WAY_W];
  assign inv_way = vl_own[WAY_W-1:0];

  // lookup path: fill wins on its own set and on the set it invalidates
  assign lk_stall = lk_valid && fill_valid &&
                    ((lk_set == fill_set) || (inv_en && (inv_set == lk_set)));
  assign lk_hit   = lk_valid && !lk_stall && lk_any;
  assign touch_en = lk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                    now_q <= '0;
    else if (touch_en || fill_done) now_q <= now_q + 1'b1;
  end

  vw_tag_store #(
    .SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_set(lk_set), .lk_tag(lk_tag), .lk_match(lk_match_vec),
    .lk_any(lk_any), .lk_way(lk_way), .lk_line(lk_line),
    .pk_set(fill_set), .pk_valid(pk_valid), .pk_stamps(pk_stamps), .pk_fptr(pk_fptr),
    .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
    .wr_en(fill_done), .wr_set(fill_set), .wr_way(new_way),
    .wr_tag(fill_tag), .wr_line(new_line),
    .touch_en(touch_en), .touch_set(lk_set), .touch_way(lk_way),
    .now(now_q)
  );

  vw_way_pick #(.WAYS(WAYS)) u_pick (
    .now(now_q), .valid(pk_valid), .stamps(pk_stamps),
    .free_any(free_any), .free_way(free_way), .lru_way(lru_way)
  );

  vw_line_store #(.LINES(LINES), .OWN_W(OWN_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_done), .wr_line(new_line), .wr_own({fill_set, new_way}),
    .rd_line(vic_line), .rd_valid(vl_valid), .rd_own(vl_own)
  );

endmodule

// File: rtl/vw_dir_chk.sv
module vw_dir_chk #(
  parameter int unsigned SET_W = 2,
  parameter int unsigned WAYS  = 16,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic [SET_W-1:0] lk_set,
  input logic             fill_valid,
  input logic [SET_W-1:0] fill_set,
  input logic             fill_done,
  input logic             vic_req,
  input logic             inv_en,
  input logic [SET_W-1:0] inv_set,
  input logic [WAY_W-1:0] inv_way,
  input logic [WAY_W-1:0] wr_way,
  input logic [WAYS-1:0]  hit_vec
);

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10
  fill_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fill_valid && (lk_set == fill_set)) |-> !lk_hit);

  // R7
  inval_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |-> fill_done);

  // R7
  inval_not_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |-> !((inv_set == fill_set) && (inv_way == wr_way)));

  // R6
  req_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_req |-> fill_valid);

  // R8
  lru_no_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && !vic_req) |-> !inv_en);

endmodule

bind vw_dir vw_dir_chk #(.SET_W(SET_W), .WAYS(WAYS)) u_vw_dir_chk (
  .clk(clk), .rst_n(rst_n),
  .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_set(lk_set),
  .fill_valid(fill_valid), .fill_set(fill_set), .fill_done(fill_done),
  .vic_req(vic_req), .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
  .wr_way(new_way), .hit_vec(lk_match_vec)
);

// File: tb/test_vw_dir.sv
module test_vw_dir;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NW = 16;
  localparam int NL = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_addr = '0;
  logic        lk_hit, lk_stall;
  logic [4:0]  lk_line;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_addr = '0;
  logic        fill_done;
  logic [4:0]  fill_line;
  logic        vic_req;
  logic        vic_gnt = 1'b0;
  logic [4:0]  vic_line = '0;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  // reference model
  bit mv [NS][NW];
  int mtag [NS][NW];
  int mfp [NS][NW];
  int mst [NS][NW];
  bit ov [NL];
  int os [NL];
  int ow [NL];
  int mtime = 1;

  vw_dir i_vw_dir (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_stall(lk_stall), .lk_line(lk_line),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_done(fill_done),
    .fill_line(fill_line), .vic_req(vic_req), .vic_gnt(vic_gnt), .vic_line(vic_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int t, input int s, input int off);
    logic [9:0] tt = 10'(t);
    logic [1:0] ss = 2'(s);
    logic [3:0] oo = 4'(off);
    return {tt, ss, oo};
  endfunction

  function automatic int mfind(input int s, input int t);
    for (int w = 0; w < NW; w++) if (mv[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int mfree(input int s);
    for (int w = 0; w < NW; w++) if (!mv[s][w]) return w;
    return -1;
  endfunction

  function automatic int mlru(input int s);
    int best = -1;
    for (int w = 0; w < NW; w++)
      if (mv[s][w] && (best < 0 || mst[s][w] < mst[s][best])) best = w;
    return best;
  endfunction

  function automatic void model_fill(input int s, input int t, input int w,
                                     input int line, input bit from_free);
    if (from_free && ov[line]) mv[os[line]][ow[line]] = 1'b0;
    mv[s][w] = 1'b1;
    mtag[s][w] = t;
    mfp[s][w] = line;
    mst[s][w] = mtime++;
    ov[line] = 1'b1;
    os[line] = s;
    ow[line] = w;
  endfunction

  task automatic lookup_chk(input int t, input int s, input int off, input string req);
    int w;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr = mk(t, s, off);
    #1;
    w = mfind(s, t);
    check({req, " hit"}, int'(lk_hit), int'(w >= 0));
    check({req, " no stall"}, int'(lk_stall), 0);
    if (w >= 0) check({req, " R3 line"}, int'(lk_line), mfp[s][w]);
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
    if (w >= 0) mst[s][w] = mtime++;
  endtask

  task automatic fill_do(input int t, input int s, input int gline, input int gdelay,
                         input string req);
    int fw, way, line;
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr = mk(t, s, $urandom_range(0, 15));
    #1;
    fw = mfree(s);
    check({req, " vic_req"}, int'(vic_req), int'(fw >= 0));
    if (fw >= 0) begin
      for (int k = 0; k < gdelay; k++) begin
        check({req, " R6 wait"}, int'(fill_done), 0);
        @(posedge clk);
        @(negedge clk);
      end
      vic_gnt = 1'b1;
      vic_line = 5'(gline);
      #1;
      check({req, " R6 done"}, int'(fill_done), 1);
      check({req, " R6 line"}, int'(fill_line), gline);
      way = fw;
      line = gline;
    end else begin
      way = mlru(s);
      line = mfp[s][way];
      check({req, " R8 done"}, int'(fill_done), 1);
      check({req, " R8 line"}, int'(fill_line), line);
    end
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
    vic_gnt = 1'b0;
    model_fill(s, t, way, line, fw >= 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int w;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: empty after reset
    lookup_chk(0, 0, 0, "R2 reset");
    lookup_chk(7, 3, 9, "R2 reset");
    check("R2 reset stall", int'(lk_stall), 0);

    // R5 / R6: one set takes 16 tags, twice an even share of lines
    for (int i = 0; i < NW; i++) fill_do(i, 0, i, i % 3, "R5 R6 deep set");
    for (int i = 0; i < NW; i++) lookup_chk(i, 0, i, "R5 deep set");

    // R1: offset ignored, set bits distinguish entries
    lookup_chk(5, 0, 0, "R1 offset 0");
    lookup_chk(5, 0, 15, "R1 offset 15");
    lookup_chk(5, 1, 3, "R1 other set");

    // R9 / R8: refresh tag 0, so tag 1 is now least recent
    lookup_chk(0, 0, 2, "R9 touch");
    for (int i = 2; i < NW; i++) lookup_chk(i, 0, 1, "R9 touch");
    fill_do(100, 0, 0, 0, "R8 full set");
    lookup_chk(1, 0, 0, "R8 evicted");
    lookup_chk(0, 0, 0, "R9 kept");
    lookup_chk(100, 0, 0, "R8 new");

    // R7: reassigning a line drops its previous owner
    fill_do(200, 1, 20, 1, "R7 first");
    fill_do(201, 2, 20, 0, "R7 second");
    check("R7 old owner dropped", mfind(1, 200), -1);
    lookup_chk(200, 1, 0, "R7 old owner");
    lookup_chk(201, 2, 0, "R7 new owner");

    // R10 / R11: pending fill to set 2
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr = mk(301, 2, 0);
    lk_valid = 1'b1;
    lk_addr = mk(201, 2, 0);
    #1;
    check("R10 stall", int'(lk_stall), 1);
    check("R10 no hit", int'(lk_hit), 0);
    check("R10 fill waits", int'(fill_done), 0);
    @(posedge clk);
    @(negedge clk);
    lk_addr = mk(0, 0, 0);
    #1;
    w = mfind(0, 0);
    check("R11 no stall", int'(lk_stall), 0);
    check("R11 hit", int'(lk_hit), 1);
    check("R11 line", int'(lk_line), mfp[0][w]);
    @(posedge clk);
    #1;
    mst[0][w] = mtime++;
    @(negedge clk);
    lk_valid = 1'b0;
    vic_gnt = 1'b1;
    vic_line = 5'd25;
    #1;
    check("R10 fill done", int'(fill_done), 1);
    check("R10 fill line", int'(fill_line), 25);
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
    vic_gnt = 1'b0;
    model_fill(2, 301, mfree(2), 25, 1'b1);
    lookup_chk(201, 2, 0, "R10 after fill");
    lookup_chk(301, 2, 0, "R10 new entry");

    // random traffic skewed to set 0
    for (int it = 0; it < 1500; it++) begin
      int s, t;
      s = ($urandom_range(0, 9) < 6) ? 0 : int'($urandom_range(1, 3));
      t = $urandom_range(0, 39);
      lookup_chk(t, s, $urandom_range(0, 15), "R3 R4 random");
      if (mfind(s, t) < 0) begin
        fill_do(t, s, $urandom_range(0, NL - 1), $urandom_range(0, 2), "R6 R7 R8 random");
        lookup_chk(t, s, $urandom_range(0, 15), "R3 refill");
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule